// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block sits beside the access controller of an asynchronous DRAM and owns the two duties that keep the memory usable: bringing it out of power-up and keeping its cells charged afterwards. After reset it stays silent for a power-up wait. It then asks for the bus a fixed number of times and runs one refresh cycle on each grant. Once those initialization cycles are complete it raises `ready` and switches to periodic operation.

In periodic operation an interval timer produces one refresh obligation per `REF_INTERVAL` clocks. The defaults spread 2048 refreshes over 32 ms at 125 MHz. Obligations that the controller has not yet granted build up in a small debt counter. The counter saturates at `DEBT_MAX`, and the tick that would push it past that limit sets a sticky overflow flag.

Each refresh is issued only while the controller holds `ref_gnt`. It uses the CAS-before-RAS strobe order, or a RAS-only cycle that presents an internal row counter on `row_addr`. The write-enable strobe stays high throughout, so the DRAM's test mode is never entered.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held: `ready`=0, `ref_req`=0, `bus_own`=0, `debt_ovf`=0, `ras_n`=`cas_n`=`we_n`=1 and `row_addr`=0.
- R2: After reset is released, `ref_req` first reads 1 exactly `PWRUP_CYC` clocks later. Until then `ras_n` and `cas_n` stay 1.
- R3: `ready` rises in the clock that follows the end of the `INIT_CNT`-th initialization refresh. It reads 0 after each earlier initialization refresh, and once it is 1 it stays 1 until reset.
- R4: `ref_req` stays 1 while a refresh is owed and no grant has come, and the strobes stay idle during that time. A refresh starts one clock after `ref_gnt`=1 is sampled with `ref_req`=1. `ref_req` falls in the clock after the last precharge clock if nothing more is owed.
- R5: In a CAS-before-RAS cycle (`ror_mode`=0 at grant), `cas_n` goes low for `T_CSR` clocks before `ras_n` falls. `cas_n` then stays low through all `T_RAS` clocks of `ras_n` low. `we_n` is 1 in every clock.
- R6: Every refresh ends with `T_RP` clocks (at least 2) in which `ras_n` and `cas_n` are both 1. `bus_own` is 1 from the first strobe clock to the last precharge clock.
- R7: In a RAS-only cycle (`ror_mode`=1 at grant), `ras_n` is low for `T_RAS` clocks while `cas_n` stays 1. `row_addr` is constant during the cycle and increments by one, modulo 2^`ROW_W`, when the cycle ends.
- R8: In periodic operation, `ref_req` rises exactly `REF_INTERVAL` clocks after `ready` rises, and every `REF_INTERVAL` clocks after that when each request is served before the next one.
- R9: Ungranted obligations accumulate up to `DEBT_MAX`, and each of them is served by one refresh. A tick that arrives at `DEBT_MAX` sets `debt_ovf` in the next clock, and `debt_ovf` then stays 1 until reset.
- R10: The refresh type is taken from `ror_mode` in the clock the grant is accepted. Changing `ror_mode` during the cycle has no effect on the strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ror_mode | input | 1 | 1 selects a RAS-only refresh, 0 selects CAS-before-RAS; sampled at grant |
| ref_gnt | input | 1 | Bus grant from the access controller |
| ready | output | 1 | Initialization done; the DRAM may be used |
| ref_req | output | 1 | Refresh owed; request for the bus |
| bus_own | output | 1 | The sequencer is driving the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_W | Row used for RAS-only refresh |
| debt_ovf | output | 1 | Sticky flag: the refresh debt passed its limit |

## Verification
Each result has a fixed latency, and the bench checks it in that clock. The strobes of a refresh appear one clock after the grant is sampled and follow a fixed per-clock shape, which the bench computes from the timing parameters. `ref_req` and `row_addr` change one clock after the last precharge clock. `ready` shows in that same clock for the final initialization cycle. A timer tick shows on `ref_req`, or on `debt_ovf` when the debt is full, one clock after the tick edge. All samples are taken on the falling clock edge, and the bench counts falling edges to place each expected change: exactly `PWRUP_CYC` clocks to the first request and `REF_INTERVAL` clocks between periodic requests. For overflow, where the timer phase is not visible, the check uses a window bounded on both sides.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    // Strobe sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE     = 2'd0,
        SQ_CAS_LEAD = 2'd1,
        SQ_RAS_LOW  = 2'd2,
        SQ_PRECHG   = 2'd3
    } strobe_st_e;

    // Life phases of the sequencer
    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_INIT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int unsigned INTERVAL = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = $clog2(INTERVAL + 1);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = 1'b0;
        if (!en) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == LAST) begin
            tick      = 1'b1;
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R8: the phase counter never runs past the interval
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);

    // R8: the timer stays at rest while disabled
    a_r8_rest_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> tmr_q.cnt <= CW'(1));

endmodule

// File: rtl/ref_debt.sv
module ref_debt #(
    parameter int unsigned DEBT_MAX = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic served,
    output logic owed,
    output logic ovf
);
    localparam int unsigned DW = $clog2(DEBT_MAX + 1);
    localparam logic [DW-1:0] CAP = DW'(DEBT_MAX);

    typedef struct packed {
        logic [DW-1:0] debt;
        logic          ovf;
    } debt_s;

    debt_s dbt_d, dbt_q;

    always_comb begin
        dbt_d = dbt_q;
        if (tick && !served) begin
            if (dbt_q.debt == CAP) dbt_d.ovf  = 1'b1;
            else                   dbt_d.debt = dbt_q.debt + DW'(1);
        end else if (!tick && served) begin
            if (dbt_q.debt != '0)  dbt_d.debt = dbt_q.debt - DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dbt_q <= '0;
        else        dbt_q <= dbt_d;
    end

    assign owed = (dbt_q.debt != '0);
    assign ovf  = dbt_q.ovf;

    // R9: debt never passes its cap
    a_r9_debt_capped: assert property (@(posedge clk) disable iff (!rst_n)
        dbt_q.debt <= CAP);

    // R9: overflow is sticky
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R9: overflow only appears when the debt was already full
    a_r9_ovf_from_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(dbt_q.debt) == CAP);

endmodule

// File: rtl/ref_strobe_seq.sv
module ref_strobe_seq
    import dram_ref_pkg::*;
#(
    parameter int unsigned T_CSR = 2,
    parameter int unsigned T_RAS = 7,
    parameter int unsigned T_RP  = 4,
    parameter int unsigned ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ror_sel,
    output logic             ras_n,
    output logic             cas_n,
    output logic             busy,
    output logic             done,
    output logic [ROW_W-1:0] row
);
    localparam int unsigned TMAX_A = (T_CSR > T_RAS) ? T_CSR : T_RAS;
    localparam int unsigned TMAX   = (TMAX_A > T_RP) ? TMAX_A : T_RP;
    localparam int unsigned CW     = $clog2(TMAX + 1);
    localparam logic [CW-1:0] CSR_LAST = CW'(T_CSR - 1);
    localparam logic [CW-1:0] RAS_LAST = CW'(T_RAS - 1);
    localparam logic [CW-1:0] RP_LAST  = CW'(T_RP - 1);

    typedef struct packed {
        strobe_st_e       st;
        logic [CW-1:0]    cnt;
        logic             ror;
        logic [ROW_W-1:0] row;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        done  = 1'b0;
        unique case (seq_q.st)
            SQ_IDLE: begin
                if (start) begin
                    seq_d.ror = ror_sel;
                    seq_d.cnt = '0;
                    seq_d.st  = ror_sel ? SQ_RAS_LOW : SQ_CAS_LEAD;
                end
            end
            SQ_CAS_LEAD: begin
                if (seq_q.cnt == CSR_LAST) begin
                    seq_d.cnt = '0;
                    seq_d.st  = SQ_RAS_LOW;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            SQ_RAS_LOW: begin
                if (seq_q.cnt == RAS_LAST) begin
                    seq_d.cnt = '0;
                    seq_d.st  = SQ_PRECHG;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            SQ_PRECHG: begin
                if (seq_q.cnt == RP_LAST) begin
                    done      = 1'b1;
                    seq_d.cnt = '0;
                    seq_d.st  = SQ_IDLE;
                    if (seq_q.ror) seq_d.row = seq_q.row + ROW_W'(1);
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy  = (seq_q.st != SQ_IDLE);
    assign ras_n = (seq_q.st != SQ_RAS_LOW);
    assign cas_n = !((seq_q.st == SQ_CAS_LEAD) ||
                     ((seq_q.st == SQ_RAS_LOW) && !seq_q.ror));
    assign row   = seq_q.row;

    // R5: in a CAS-before-RAS cycle the column strobe is already low when RAS falls
    a_r5_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !seq_q.ror) |-> $past(!cas_n));

    // R6: RAS rising is followed by a further precharge clock with both strobes high
    a_r6_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> (ras_n && cas_n));

    // R7: a RAS-only cycle never lowers CAS
    a_r7_ror_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seq_q.ror) |-> cas_n);

    // R7: row advances by one after each RAS-only cycle
    a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (done && seq_q.ror) |=> row == $past(row) + ROW_W'(1));

    // R7: row is steady while the strobes are active
    a_r7_row_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(row));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_ref_pkg::*;
#(
    parameter int unsigned PWRUP_CYC    = 25000,
    parameter int unsigned INIT_CNT     = 8,
    parameter int unsigned REF_INTERVAL = 1950,
    parameter int unsigned T_CSR        = 2,
    parameter int unsigned T_RAS        = 7,
    parameter int unsigned T_RP         = 4,
    parameter int unsigned DEBT_MAX     = 7,
    parameter int unsigned ROW_W        = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ror_mode,
    input  logic             ref_gnt,
    output logic             ready,
    output logic             ref_req,
    output logic             bus_own,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             debt_ovf
);
    localparam int unsigned WW = $clog2(PWRUP_CYC + 1);
    localparam int unsigned IW = $clog2(INIT_CNT + 1);
    localparam logic [WW-1:0] WAIT_LAST = WW'(PWRUP_CYC - 1);
    localparam logic [IW-1:0] INIT_LOAD = IW'(INIT_CNT);

    typedef struct packed {
        phase_e        phase;
        logic [WW-1:0] wait_cnt;
        logic [IW-1:0] init_left;
    } top_s;

    top_s top_d, top_q;

    logic tick, owed, seq_done, seq_busy, start, served;

    always_comb begin
        top_d = top_q;
        unique case (top_q.phase)
            PH_WAIT: begin
                if (top_q.wait_cnt == WAIT_LAST) top_d.phase    = PH_INIT;
                else                             top_d.wait_cnt = top_q.wait_cnt + WW'(1);
            end
            PH_INIT: begin
                if (seq_done) begin
                    top_d.init_left = top_q.init_left - IW'(1);
                    if (top_q.init_left == IW'(1)) top_d.phase = PH_RUN;
                end
            end
            PH_RUN:  ;
            default: top_d.phase = PH_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '{phase: PH_WAIT, wait_cnt: '0, init_left: INIT_LOAD};
        else        top_q <= top_d;
    end

    assign ready   = (top_q.phase == PH_RUN);
    assign ref_req = (top_q.phase == PH_INIT) || (ready && owed);
    assign start   = ref_req && ref_gnt && !seq_busy;
    assign served  = seq_done && ready;
    assign bus_own = seq_busy;
    assign we_n    = 1'b1;

    ref_interval_timer #(.INTERVAL(REF_INTERVAL)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ready),
        .tick  (tick)
    );

    ref_debt #(.DEBT_MAX(DEBT_MAX)) i_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .served (served),
        .owed   (owed),
        .ovf    (debt_ovf)
    );

    ref_strobe_seq #(
        .T_CSR (T_CSR),
        .T_RAS (T_RAS),
        .T_RP  (T_RP),
        .ROW_W (ROW_W)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .ror_sel (ror_mode),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .busy    (seq_busy),
        .done    (seq_done),
        .row     (row_addr)
    );

    // R2: nothing is requested or strobed during the power-up wait
    a_r2_quiet_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (top_q.phase == PH_WAIT) |-> (ras_n && cas_n && !ref_req));

    // R3: ready never drops once raised
    a_r3_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R3: ready rises only at the end of a refresh cycle
    a_r3_ready_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(seq_done));

    // R4: an ungranted request is held
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !bus_own && !ref_gnt) |=> ref_req);

    // R4: the bus is only taken after a grant of a pending request
    a_r4_take_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_own) |-> $past(ref_gnt && ref_req));

endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;

    localparam int TB_PWRUP = 50;
    localparam int TB_INIT  = 8;
    localparam int TB_INTV  = 40;
    localparam int TB_CSR   = 2;
    localparam int TB_RAS   = 7;
    localparam int TB_RP    = 4;
    localparam int TB_DEBT  = 3;
    localparam int TB_ROW_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ror_mode = 1'b0;
    logic ref_gnt = 1'b0;
    logic ready, ref_req, bus_own, ras_n, cas_n, we_n, debt_ovf;
    logic [TB_ROW_W-1:0] row_addr;

    int n_run = 0;
    int n_fail = 0;
    int ncyc = 0;

    // 125 MHz: 8 time units per period
    always #4 clk = ~clk;

    dram_refresh_seq #(
        .PWRUP_CYC    (TB_PWRUP),
        .INIT_CNT     (TB_INIT),
        .REF_INTERVAL (TB_INTV),
        .T_CSR        (TB_CSR),
        .T_RAS        (TB_RAS),
        .T_RP         (TB_RP),
        .DEBT_MAX     (TB_DEBT),
        .ROW_W        (TB_ROW_W)
    ) i_dram_refresh_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ror_mode (ror_mode),
        .ref_gnt  (ref_gnt),
        .ready    (ready),
        .ref_req  (ref_req),
        .bus_own  (bus_own),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .row_addr (row_addr),
        .debt_ovf (debt_ovf)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        ncyc++;
    endtask

    function automatic int seq_len(input bit ror);
        return ror ? (TB_RAS + TB_RP) : (TB_CSR + TB_RAS + TB_RP);
    endfunction

    function automatic bit exp_ras_n(input bit ror, input int i);
        int s = ror ? 0 : TB_CSR;
        return !((i >= s) && (i < s + TB_RAS));
    endfunction

    function automatic bit exp_cas_n(input bit ror, input int i);
        return ror ? 1'b1 : !(i < TB_CSR + TB_RAS);
    endfunction

    function automatic int next_row(input int r);
        return (r + 1) & ((1 << TB_ROW_W) - 1);
    endfunction

    // One granted refresh, checked clock by clock from the falling edge where ref_req is seen
    task automatic run_refresh(input bit ror, input int delay, input bit flip, input bit exp_req_after);
        int prev_row;
        int len;
        string tag;
        len = seq_len(ror);
        chk(ref_req == 1'b1, "R4 request pending before grant", int'(ref_req), 1);
        for (int d = 0; d < delay; d++) begin
            step();
            chk(ref_req && !bus_own && ras_n && cas_n, "R4 held and idle without grant",
                int'({ref_req, bus_own, ras_n, cas_n}), 4'b1011);
        end
        ror_mode = ror;
        ref_gnt  = 1'b1;
        prev_row = int'(row_addr);
        for (int i = 0; i <= len; i++) begin
            step();
            if (i == 0) begin
                ref_gnt = 1'b0;
                if (flip) ror_mode = !ror;
            end
            if (i < len) begin
                if (flip)                       tag = "R10 type latched at grant";
                else if (i >= len - TB_RP)      tag = "R6 precharge";
                else if (ror)                   tag = "R7 RAS-only strobes";
                else                            tag = "R5 CAS-before-RAS strobes";
                chk(ras_n == exp_ras_n(ror, i), tag, int'(ras_n), int'(exp_ras_n(ror, i)));
                chk(cas_n == exp_cas_n(ror, i), tag, int'(cas_n), int'(exp_cas_n(ror, i)));
                chk(bus_own == 1'b1, "R6 bus owned during cycle", int'(bus_own), 1);
                chk(we_n == 1'b1, "R5 write enable high", int'(we_n), 1);
                chk(int'(row_addr) == prev_row, "R7 row steady in cycle", int'(row_addr), prev_row);
            end else begin
                chk(bus_own == 1'b0, "R6 bus released", int'(bus_own), 0);
                chk(ref_req == exp_req_after, "R4 request after completion",
                    int'(ref_req), int'(exp_req_after));
                if (ror)
                    chk(int'(row_addr) == next_row(prev_row), "R7 row advance",
                        int'(row_addr), next_row(prev_row));
                else
                    chk(int'(row_addr) == prev_row, "R7 row kept on CAS-before-RAS",
                        int'(row_addr), prev_row);
            end
        end
    endtask

    task automatic wait_req();
        int guard = 0;
        while (!ref_req && guard < 4 * TB_INTV) begin
            step();
            guard++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..: actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        bit quiet;
        int t_ready;
        int prev_t;
        int t0;
        bit mode;
        void'($urandom(32'd20240611));

        repeat (3) step();
        chk(ready == 1'b0, "R1 reset ready", int'(ready), 0);
        chk(ref_req == 1'b0, "R1 reset request", int'(ref_req), 0);
        chk(bus_own == 1'b0, "R1 reset bus_own", int'(bus_own), 0);
        chk(debt_ovf == 1'b0, "R1 reset overflow", int'(debt_ovf), 0);
        chk(ras_n && cas_n && we_n, "R1 reset strobes", int'({ras_n, cas_n, we_n}), 7);
        chk(row_addr == '0, "R1 reset row", int'(row_addr), 0);

        rst_n = 1'b1;
        cnt = 0;
        quiet = 1'b1;
        do begin
            step();
            cnt++;
            if (!(ras_n && cas_n)) quiet = 1'b0;
        end while (!ref_req && cnt < TB_PWRUP + 10);
        chk(cnt == TB_PWRUP, "R2 power-up wait length", cnt, TB_PWRUP);
        chk(quiet, "R2 strobes quiet during wait", int'(quiet), 1);

        // Initialization refreshes, random type and grant delay
        for (int k = 0; k < TB_INIT; k++) begin
            mode = 1'($urandom_range(0, 1));
            run_refresh(mode, int'($urandom_range(0, 3)), (k == 2), (k < TB_INIT - 1));
            chk(ready == (k == TB_INIT - 1), "R3 ready after init count",
                int'(ready), int'(k == TB_INIT - 1));
        end
        t_ready = ncyc;

        // Periodic operation
        prev_t = t_ready;
        for (int j = 0; j < 30; j++) begin
            wait_req();
            chk(ncyc - prev_t == TB_INTV, "R8 refresh period", ncyc - prev_t, TB_INTV);
            chk(ready == 1'b1, "R3 ready holds", int'(ready), 1);
            prev_t = ncyc;
            if (j >= 5 && j < 25) mode = 1'b1;
            else                  mode = 1'($urandom_range(0, 1));
            run_refresh(mode, int'($urandom_range(0, 5)), ($urandom_range(0, 3) == 0), 1'b0);
        end

        // Debt accumulation and overflow
        t0 = ncyc;
        chk(debt_ovf == 1'b0, "R9 no overflow while served", int'(debt_ovf), 0);
        repeat (TB_DEBT * TB_INTV) step();
        chk(debt_ovf == 1'b0, "R9 no overflow at full debt", int'(debt_ovf), 0);
        chk(ref_req == 1'b1, "R9 debt pending", int'(ref_req), 1);
        cnt = 0;
        while (!debt_ovf && cnt < TB_INTV + 5) begin
            step();
            cnt++;
        end
        chk(debt_ovf == 1'b1, "R9 overflow raised", int'(debt_ovf), 1);
        chk(ncyc <= t0 + (TB_DEBT + 1) * TB_INTV + 1, "R9 overflow timing",
            ncyc - t0, (TB_DEBT + 1) * TB_INTV + 1);
        for (int k = 0; k < TB_DEBT; k++) begin
            run_refresh(1'b1, 0, 1'b0, (k < TB_DEBT - 1));
        end
        chk(debt_ovf == 1'b1, "R9 overflow sticky", int'(debt_ovf), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule